// File: doc/BRIEF.md
# Configurable Oscillator-Mixing Downconverter

This block takes real samples from a converter, `LANES` of them on every clock beat. It mixes each sample against a numerically controlled oscillator and delivers a decimated complex I/Q stream, one output for every eight input samples. The oscillator has a 32-bit phase accumulator, a 32-bit frequency step and a 32-bit phase offset. The offset is added to each lane's running phase, and the top six bits of the result address a quarter-wave sine table.

A two-bit output selector chooses what gets decimated. It can pass the complex mixer product, the oscillator itself (useful for calibration), or the unmixed input on the I rail. Decimation sums each group of eight consecutive per-sample values and keeps the floor of their mean.

Software writes settings into shadow registers through a simple write port. A commit strobe copies all of them together into a pending set. The pending set becomes active only at the boundary of a decimation group, so no output sample mixes two configurations. A mode bit selects either continuous output or a one-shot burst of a programmed number of outputs.

Top module: `ddc_downconv`

## Requirements
- R1: After reset `outValid` is low and the active settings are frequency 0, phase 0, sample count 10, product output and continuous mode.
- R2: Register writes (address 0 frequency [31:0], 1 phase offset [31:0], 2 sample count [15:0], 3 selector [1:0], 4 mode [0], 5 commit strobe [0]) change nothing at the output until the commit strobe bit goes from 0 to 1. Software then writes it back to 0.
- R3: A commit made while a group is partly received takes effect at the first beat of the next group. Every output is computed with one configuration.
- R4: Lane k (lane 0 at the least significant bits of `sampleIn`) uses phase `acc + k*freq + phaseOffset`. The top 6 bits index a sine table of amplitude 32767: 23170 at odd eighth turns, 32767 at a quarter turn, and cosine is the sine a quarter turn later. `acc` clears when new settings apply and then advances by `LANES*freq` on every valid beat.
- R5: Selector 0 gives per-sample I = floor(x*cos/32768) and Q = floor(x*sin/32768).
- R6: Selector 1 gives per-sample I = cos and Q = sin of the lane phase.
- R7: Selector 2 gives I = x and Q = 0. Selector 3 gives zero on both rails.
- R8: Each output is the floor of the mean (arithmetic shift right by 3) of eight consecutive per-sample values, taken from `8/LANES` valid beats that may be separated by idle cycles.
- R9: `outValid` is a one-cycle pulse, high in the second cycle after the cycle that presents a group's last beat. `outI`/`outQ` change only together with `outValid`.
- R10: In count mode (mode 0) exactly `count` outputs follow the apply, then none until the next apply. A count of 0 gives none.
- R11: In continuous mode (mode 1) every complete group produces an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| sampleValid | input | 1 | A beat of samples is present |
| sampleIn | input | LANES*SAMPLE_W | Signed input samples, lane 0 in the low bits |
| outValid | output | 1 | Decimated output strobe |
| outI | output | SAMPLE_W | Decimated in-phase value |
| outQ | output | SAMPLE_W | Decimated quadrature value |

## Verification
The bench places a commit between the two beats of a group. A design that applied it at once would emit one output blending bypass and oscillator values. Another scenario writes every shadow register without committing, and a design that leaked the shadows would change the very next output. Count mode is run with counts 3, 2 and 0 over more groups than the count. An off-by-one in the remaining-output counter shows as one output too many or too few. Negative inputs and idle gaps between beats expose a truncating rather than flooring average, or a group counter that advances on idle cycles. Oscillator sweeps in eighth turns expose a wrong lane phase step or an accumulator that is not cleared on apply.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int PHASE_W  = 32;
  localparam int LUT_BITS = 6;
  localparam int LUT_W    = 16;
  localparam int CNT_W    = 16;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_FREQ   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PHASE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SEL    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_COMMIT = 3'd5;

  typedef enum logic [1:0] {
    SEL_PRODUCT = 2'd0,
    SEL_OSC     = 2'd1,
    SEL_BYPASS  = 2'd2,
    SEL_ZERO    = 2'd3
  } outSel_e;

  typedef struct packed {
    logic [PHASE_W-1:0] freq;
    logic [PHASE_W-1:0] phase;
    outSel_e            sel;
  } mixCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic beat;        // a valid beat is consumed this cycle
    logic firstBeat;   // beat opens a group
    logic lastBeat;    // beat closes a group
    logic emit;        // closing beat whose group produces an output
    logic restartAcc;  // new settings apply this cycle
  } dpStrobe_t;
endpackage

// File: rtl/ddc_sincos.sv
module ddc_sincos
  import ddc_pkg::*;
(
  input  logic [LUT_BITS-1:0]     lutIdx,
  output logic signed [LUT_W-1:0] cosVal,
  output logic signed [LUT_W-1:0] sinVal
);
  localparam int SUB_W = LUT_BITS - 2;
  localparam logic [LUT_BITS-1:0] QUARTER = LUT_BITS'(1 << SUB_W);

  function automatic logic signed [LUT_W-1:0] quarterMag(input logic [SUB_W:0] k);
    case (k)
      5'd0:  quarterMag = 16'sd0;
      5'd1:  quarterMag = 16'sd3212;
      5'd2:  quarterMag = 16'sd6393;
      5'd3:  quarterMag = 16'sd9512;
      5'd4:  quarterMag = 16'sd12539;
      5'd5:  quarterMag = 16'sd15446;
      5'd6:  quarterMag = 16'sd18204;
      5'd7:  quarterMag = 16'sd20787;
      5'd8:  quarterMag = 16'sd23170;
      5'd9:  quarterMag = 16'sd25329;
      5'd10: quarterMag = 16'sd27245;
      5'd11: quarterMag = 16'sd28898;
      5'd12: quarterMag = 16'sd30273;
      5'd13: quarterMag = 16'sd31356;
      5'd14: quarterMag = 16'sd32137;
      5'd15: quarterMag = 16'sd32609;
      default: quarterMag = 16'sd32767;
    endcase
  endfunction

  function automatic logic signed [LUT_W-1:0] sineOf(input logic [LUT_BITS-1:0] idx);
    logic [1:0]       quad;
    logic [SUB_W:0]   step;
    logic signed [LUT_W-1:0] mag;
    quad = idx[LUT_BITS-1 -: 2];
    step = {1'b0, idx[SUB_W-1:0]};
    if (quad[0]) step = (SUB_W+1)'(1 << SUB_W) - step;
    mag = quarterMag(step);
    sineOf = quad[1] ? -mag : mag;
  endfunction

  always_comb begin
    sinVal = sineOf(lutIdx);
    cosVal = sineOf(lutIdx + QUARTER);
  end
endmodule

// File: rtl/ddc_ctrl.sv
module ddc_ctrl
  import ddc_pkg::*;
#(
  parameter int GROUP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              sampleValid,
  output mixCfg_t           cfg,
  output dpStrobe_t         stb
);
  localparam int GC_W = (GROUP_CYCLES > 1) ? $clog2(GROUP_CYCLES) : 1;
  localparam logic [GC_W-1:0] LAST_CNT = GC_W'(GROUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] RESET_COUNT = CNT_W'(10);
  localparam mixCfg_t RESET_CFG = '{freq: '0, phase: '0, sel: SEL_PRODUCT};

  mixCfg_t shadowCfg, pendCfg, actCfg, effCfg;
  logic shadowMode, pendMode, actMode, effMode;
  logic [CNT_W-1:0] shadowCount, pendCount, remaining, remBase;
  logic strobeReg, strobeSeen, commitPulse, pendValid;
  logic [GC_W-1:0] groupCnt;
  logic groupEmit, atBoundary, applyNow, startEmit, curEmit;
  logic firstBeat, lastBeat;

  assign commitPulse = strobeReg & ~strobeSeen;
  assign atBoundary  = (groupCnt == '0);
  assign applyNow    = atBoundary & pendValid;
  assign effCfg      = applyNow ? pendCfg : actCfg;
  assign effMode     = applyNow ? pendMode : actMode;
  assign remBase     = applyNow ? pendCount : remaining;
  assign startEmit   = effMode | (remBase != '0);
  assign curEmit     = atBoundary ? startEmit : groupEmit;
  assign firstBeat   = sampleValid & atBoundary;
  assign lastBeat    = sampleValid & (groupCnt == LAST_CNT);

  assign cfg = effCfg;
  assign stb = '{beat: sampleValid, firstBeat: firstBeat, lastBeat: lastBeat,
                 emit: lastBeat & curEmit, restartAcc: applyNow};

  // shadow register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg   <= RESET_CFG;
      shadowMode  <= 1'b1;
      shadowCount <= RESET_COUNT;
      strobeReg   <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_FREQ:   shadowCfg.freq  <= regWrData[PHASE_W-1:0];
        ADDR_PHASE:  shadowCfg.phase <= regWrData[PHASE_W-1:0];
        ADDR_COUNT:  shadowCount     <= regWrData[CNT_W-1:0];
        ADDR_SEL:    shadowCfg.sel   <= outSel_e'(regWrData[1:0]);
        ADDR_MODE:   shadowMode      <= regWrData[0];
        ADDR_COMMIT: strobeReg       <= regWrData[0];
        default: ;
      endcase
    end
  end

  // commit snapshot and group-boundary apply
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeSeen <= 1'b0;
      pendCfg    <= RESET_CFG;
      pendMode   <= 1'b1;
      pendCount  <= RESET_COUNT;
      pendValid  <= 1'b0;
      actCfg     <= RESET_CFG;
      actMode    <= 1'b1;
    end else begin
      strobeSeen <= strobeReg;
      if (commitPulse) begin
        pendCfg   <= shadowCfg;
        pendMode  <= shadowMode;
        pendCount <= shadowCount;
        pendValid <= 1'b1;
      end else if (applyNow) begin
        pendValid <= 1'b0;
      end
      if (applyNow) begin
        actCfg  <= pendCfg;
        actMode <= pendMode;
      end
    end
  end

  // group tracking and burst count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupCnt  <= '0;
      groupEmit <= 1'b0;
      remaining <= RESET_COUNT;
    end else begin
      if (sampleValid) groupCnt <= (groupCnt == LAST_CNT) ? '0 : groupCnt + 1'b1;
      if (firstBeat) groupEmit <= startEmit;
      if (firstBeat && startEmit && !effMode) remaining <= remBase - 1'b1;
      else if (applyNow)                      remaining <= pendCount;
    end
  end
endmodule

// File: rtl/ddc_datapath.sv
module ddc_datapath
  import ddc_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 16,
  parameter int DECIM    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [LANES*SAMPLE_W-1:0]  sampleIn,
  input  mixCfg_t                    cfg,
  input  dpStrobe_t                  stb,
  output logic                       outValid,
  output logic [SAMPLE_W-1:0]        outI,
  output logic [SAMPLE_W-1:0]        outQ
);
  localparam int SHIFT  = $clog2(DECIM);
  localparam int SUM_W  = SAMPLE_W + SHIFT;
  localparam int BEAT_W = SAMPLE_W + $clog2(LANES);

  function automatic logic signed [SAMPLE_W-1:0] mulScale(
      input logic signed [SAMPLE_W-1:0] a, input logic signed [LUT_W-1:0] b);
    logic signed [SAMPLE_W+LUT_W-1:0] p;
    p = a * b;
    mulScale = p[LUT_W-1 +: SAMPLE_W];
  endfunction

  function automatic logic [LUT_BITS-1:0] topBits(input logic [PHASE_W-1:0] ph);
    topBits = ph[PHASE_W-1 -: LUT_BITS];
  endfunction

  logic [PHASE_W-1:0] phaseAcc, baseAcc;
  logic signed [SAMPLE_W-1:0] laneI [LANES];
  logic signed [SAMPLE_W-1:0] laneQ [LANES];
  logic signed [BEAT_W-1:0] beatI, beatQ, s1I, s1Q;
  logic s1Valid, s1First, s1Last, s1Emit;
  logic signed [SUM_W-1:0] groupI, groupQ, totalI, totalQ;

  assign baseAcc = stb.restartAcc ? '0 : phaseAcc;

  always_ff @(posedge clk) begin
    if (!rstN) phaseAcc <= '0;
    else       phaseAcc <= baseAcc + (stb.beat ? PHASE_W'(LANES) * cfg.freq : '0);
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [PHASE_W-1:0] lanePhase;
    logic signed [LUT_W-1:0] cosV, sinV;
    logic signed [SAMPLE_W-1:0] x;

    assign lanePhase = baseAcc + PHASE_W'(g) * cfg.freq + cfg.phase;
    assign x = sampleIn[g*SAMPLE_W +: SAMPLE_W];

    ddc_sincos u_lut (
      .lutIdx (topBits(lanePhase)),
      .cosVal (cosV),
      .sinVal (sinV)
    );

    always_comb begin
      case (cfg.sel)
        SEL_PRODUCT: begin laneI[g] = mulScale(x, cosV); laneQ[g] = mulScale(x, sinV); end
        SEL_OSC:     begin laneI[g] = SAMPLE_W'(cosV);    laneQ[g] = SAMPLE_W'(sinV); end
        SEL_BYPASS:  begin laneI[g] = x;                  laneQ[g] = '0; end
        default:     begin laneI[g] = '0;                 laneQ[g] = '0; end
      endcase
    end
  end

  always_comb begin
    beatI = '0;
    beatQ = '0;
    for (int k = 0; k < LANES; k++) begin
      beatI = beatI + BEAT_W'(laneI[k]);
      beatQ = beatQ + BEAT_W'(laneQ[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0; s1First <= 1'b0; s1Last <= 1'b0; s1Emit <= 1'b0;
      s1I <= '0; s1Q <= '0;
    end else begin
      s1Valid <= stb.beat;
      s1First <= stb.firstBeat;
      s1Last  <= stb.lastBeat;
      s1Emit  <= stb.emit;
      if (stb.beat) begin
        s1I <= beatI;
        s1Q <= beatQ;
      end
    end
  end

  assign totalI = (s1First ? '0 : groupI) + SUM_W'(s1I);
  assign totalQ = (s1First ? '0 : groupQ) + SUM_W'(s1Q);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupI <= '0; groupQ <= '0;
      outValid <= 1'b0; outI <= '0; outQ <= '0;
    end else begin
      if (s1Valid) begin
        groupI <= totalI;
        groupQ <= totalQ;
      end
      outValid <= s1Valid & s1Last & s1Emit;
      if (s1Valid && s1Last && s1Emit) begin
        outI <= totalI[SHIFT +: SAMPLE_W];
        outQ <= totalQ[SHIFT +: SAMPLE_W];
      end
    end
  end
endmodule

// File: rtl/ddc_downconv.sv
module ddc_downconv
  import ddc_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 16,
  parameter int DECIM    = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [REG_W-1:0]          regWrData,
  input  logic                      sampleValid,
  input  logic [LANES*SAMPLE_W-1:0] sampleIn,
  output logic                      outValid,
  output logic [SAMPLE_W-1:0]       outI,
  output logic [SAMPLE_W-1:0]       outQ
);
  localparam int GROUP_CYCLES = DECIM / LANES;

  mixCfg_t   cfg;
  dpStrobe_t stb;

  logic applyNow, emitNow, beatNow, firstNow;
  logic [PHASE_W-1:0] effFreq;
  assign applyNow = stb.restartAcc;
  assign emitNow  = stb.emit;
  assign beatNow  = stb.beat;
  assign firstNow = stb.firstBeat;
  assign effFreq  = cfg.freq;

  ddc_ctrl #(.GROUP_CYCLES(GROUP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .sampleValid(sampleValid), .cfg(cfg), .stb(stb)
  );

  ddc_datapath #(.LANES(LANES), .SAMPLE_W(SAMPLE_W), .DECIM(DECIM)) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .cfg(cfg), .stb(stb),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );
endmodule

// File: rtl/ddc_downconv_chk.sv
module ddc_downconv_chk #(
  parameter int SAMPLE_W = 16,
  parameter int PHASE_W  = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                outValid,
  input logic [SAMPLE_W-1:0] outI,
  input logic [SAMPLE_W-1:0] outQ,
  input logic                applyNow,
  input logic                emitNow,
  input logic                beatNow,
  input logic                firstNow,
  input logic [PHASE_W-1:0]  effFreq
);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R9
  latency_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    emitNow |=> ##1 outValid);

  // R9
  latency_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(emitNow, 2));

  // R9
  hold_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((outI != $past(outI)) || (outQ != $past(outQ))) |-> outValid);

  // R2
  freq_commit_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (effFreq != $past(effFreq)) |-> applyNow);

  // R3
  apply_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (applyNow && beatNow) |-> firstNow);
endmodule

bind ddc_downconv ddc_downconv_chk #(.SAMPLE_W(SAMPLE_W), .PHASE_W(ddc_pkg::PHASE_W)) u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outI(outI), .outQ(outQ),
  .applyNow(applyNow), .emitNow(emitNow), .beatNow(beatNow),
  .firstNow(firstNow), .effFreq(effFreq)
);

// File: tb/ddc_downconv_bench.sv
`timescale 1ns/1ps
module ddc_downconv_bench;
  localparam int LANES = 4;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic sampleValid = 1'b0;
  logic [LANES*SW-1:0] sampleIn = '0;
  logic outValid;
  logic [SW-1:0] outI, outQ;

  always #2 clk = ~clk;

  ddc_downconv u_ddc_downconv (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int gotI[$], gotQ[$], expI[$], expQ[$];
  bit prevValid = 0;
  int backToBack = 0;

  // reference model state
  logic [31:0] mFreq = 0, mPhase = 0, mAcc = 0;
  int mSel = 0, mMode = 1, mRemain = 10;
  logic [31:0] pFreq, pPhase;
  int pSel, pMode, pCount;
  bit pendV = 0;
  int mPos = 0, mSumI = 0, mSumQ = 0;
  bit mEmit = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && outValid) begin
      gotI.push_back(int'($signed(outI)));
      gotQ.push_back(int'($signed(outQ)));
      if (prevValid) backToBack++;
    end
    prevValid = outValid;
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int sinE(input logic [31:0] ph);
    case (ph[31:29])
      3'd0: sinE = 0;      3'd1: sinE = 23170;
      3'd2: sinE = 32767;  3'd3: sinE = 23170;
      3'd4: sinE = 0;      3'd5: sinE = -23170;
      3'd6: sinE = -32767; default: sinE = -23170;
    endcase
  endfunction

  function automatic int mix(input int x, input int c);
    longint p;
    p = longint'(x) * longint'(c);
    mix = int'(p >>> 15);
  endfunction

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    sampleValid = 1'b0;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b0;
    end
  endtask

  task automatic commitCfg(input logic [31:0] f, input logic [31:0] ph,
                           input int sel, input int mode, input int cnt);
    writeReg(3'd0, f);
    writeReg(3'd1, ph);
    writeReg(3'd2, 32'(cnt));
    writeReg(3'd3, 32'(sel));
    writeReg(3'd4, 32'(mode));
    writeReg(3'd5, 32'd1);
    writeReg(3'd5, 32'd0);
    pFreq = f; pPhase = ph; pSel = sel; pMode = mode; pCount = cnt; pendV = 1;
    idle(3);
  endtask

  task automatic beat(input int x0, input int x1, input int x2, input int x3);
    int xs[4];
    xs = '{x0, x1, x2, x3};
    if (mPos == 0 && pendV) begin
      mFreq = pFreq; mPhase = pPhase; mSel = pSel; mMode = pMode;
      mRemain = pCount; mAcc = 0; pendV = 0;
    end
    if (mPos == 0) begin
      mEmit = (mMode != 0) || (mRemain != 0);
      if (mEmit && mMode == 0) mRemain--;
      mSumI = 0; mSumQ = 0;
    end
    for (int k = 0; k < LANES; k++) begin
      logic [31:0] ph;
      int c, s;
      ph = mAcc + 32'(k) * mFreq + mPhase;
      s = sinE(ph);
      c = sinE(ph + 32'h4000_0000);
      case (mSel)
        0: begin mSumI += mix(xs[k], c); mSumQ += mix(xs[k], s); end
        1: begin mSumI += c; mSumQ += s; end
        2: begin mSumI += xs[k]; end
        default: ;
      endcase
    end
    mAcc = mAcc + 32'd4 * mFreq;
    mPos++;
    if (mPos == 2) begin
      mPos = 0;
      if (mEmit) begin
        expI.push_back(mSumI >>> 3);
        expQ.push_back(mSumQ >>> 3);
      end
    end
    @(negedge clk);
    regWrEn = 1'b0;
    sampleValid = 1'b1;
    sampleIn = {16'(x3), 16'(x2), 16'(x1), 16'(x0)};
  endtask

  task automatic compare(input string req);
    int n;
    idle(4);
    check({req, " output count"}, gotI.size(), expI.size());
    n = (gotI.size() < expI.size()) ? gotI.size() : expI.size();
    for (int i = 0; i < n; i++) begin
      check({req, " I"}, gotI[i], expI[i]);
      check({req, " Q"}, gotQ[i], expQ[i]);
    end
    gotI.delete(); gotQ.delete(); expI.delete(); expQ.delete();
  endtask

  // R1, R5, R11: defaults give continuous product output
  task automatic t_reset();
    check("R1 outValid low after reset", int'(outValid), 0);
    beat(1000, 1000, 1000, 1000); beat(1000, 1000, 1000, 1000);
    beat(-1000, 200, -3, 7); beat(32767, -32768, 5, -5);
    compare("R1");
  endtask

  // R5: product with quarter and eighth offsets, negative inputs
  task automatic t_product();
    commitCfg(32'h0, 32'h4000_0000, 0, 1, 10);
    beat(1000, -1000, 12345, -7); beat(-32768, 32767, 1, -1);
    commitCfg(32'h0, 32'h2000_0000, 0, 1, 10);
    beat(30000, -30000, 555, -556); beat(2, 3, -4, 9);
    compare("R5");
  endtask

  // R6, R4: oscillator output with lane phase steps and accumulator
  task automatic t_osc();
    commitCfg(32'h0, 32'h2000_0000, 1, 1, 10);
    beat(0, 0, 0, 0); beat(0, 0, 0, 0);
    commitCfg(32'h2000_0000, 32'h0, 1, 1, 10);
    for (int g = 0; g < 3; g++) begin beat(1, 2, 3, 4); beat(5, 6, 7, 8); end
    compare("R6 R4");
  endtask

  // R4: accumulator restart and advance under the product
  task automatic t_accum();
    commitCfg(32'h6000_0000, 32'h2000_0000, 0, 1, 10);
    for (int g = 0; g < 3; g++) begin beat(9000, -4000, 300, 20000); beat(-1, 1, 777, -777); end
    compare("R4");
  endtask

  // R7: bypass floors the mean, selector 3 yields zero
  task automatic t_bypass();
    commitCfg(32'h0, 32'h0, 2, 1, 10);
    beat(-1, -1, -1, -1); beat(-1, -1, -1, -2);
    beat(100, 200, 300, 400); beat(-5, 6, -7, 8);
    commitCfg(32'h0, 32'h0, 3, 1, 10);
    beat(100, 200, 300, 400); beat(1, 2, 3, 4);
    compare("R7");
  endtask

  // R8: idle gaps between beats of a group
  task automatic t_gaps();
    commitCfg(32'h0, 32'h0, 2, 1, 10);
    beat(10, 20, 30, 40); idle(3); beat(50, 60, 70, 81); idle(5);
    beat(-9, 0, 0, 0); idle(1); beat(0, 0, 0, 0);
    compare("R8");
  endtask

  // R2: shadow writes without a commit change nothing
  task automatic t_shadow();
    commitCfg(32'h0, 32'h0, 0, 1, 10);
    writeReg(3'd3, 32'd2);
    writeReg(3'd1, 32'h4000_0000);
    writeReg(3'd0, 32'h2000_0000);
    writeReg(3'd4, 32'd0);
    writeReg(3'd2, 32'd0);
    beat(4000, 4000, 4000, 4000); beat(4000, 4000, 4000, 4000);
    beat(4000, 4000, 4000, 4000); beat(4000, 4000, 4000, 4000);
    compare("R2");
  endtask

  // R3: commit between the beats of one group
  task automatic t_midgroup();
    commitCfg(32'h0, 32'h0, 2, 1, 10);
    beat(11, 22, 33, 44);
    commitCfg(32'h0, 32'h2000_0000, 1, 1, 10);
    beat(55, 66, 77, 88);
    beat(1, 1, 1, 1); beat(1, 1, 1, 1);
    compare("R3");
  endtask

  // R10: burst counts 3, 2 and 0
  task automatic t_count();
    commitCfg(32'h0, 32'h0, 2, 0, 3);
    for (int g = 0; g < 5; g++) begin beat(g, g, g, g); beat(8, 8, 8, 8); end
    compare("R10 count 3");
    commitCfg(32'h0, 32'h0, 2, 0, 2);
    for (int g = 0; g < 4; g++) begin beat(-g, 1, 2, 3); beat(4, 5, 6, 7); end
    compare("R10 count 2");
    commitCfg(32'h0, 32'h0, 2, 0, 0);
    for (int g = 0; g < 3; g++) begin beat(5, 5, 5, 5); beat(5, 5, 5, 5); end
    compare("R10 count 0");
  endtask

  // R9, R11: latency, single pulses, continuous back-to-back groups
  task automatic t_timing();
    commitCfg(32'h0, 32'h0, 2, 1, 10);
    beat(8, 8, 8, 8); beat(8, 8, 8, 8);
    @(negedge clk);
    sampleValid = 1'b0;
    check("R9 no output one cycle after last beat", int'(outValid), 0);
    @(negedge clk);
    check("R9 output two cycles after last beat", int'(outValid), 1);
    backToBack = 0;
    for (int g = 0; g < 6; g++) begin beat(g, 1, 2, 3); beat(3, 2, 1, g); end
    compare("R11");
    check("R9 outValid single-cycle pulses", backToBack, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset_pre();
  end

  task automatic t_reset_pre();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_product();
    t_osc();
    t_accum();
    t_bypass();
    t_gaps();
    t_shadow();
    t_midgroup();
    t_count();
    t_timing();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask
endmodule